// File: doc/BRIEF.md
# Delayed-Branch Program Counter Unit

This block produces the instruction fetch address for a three-stage core (fetch, decode, execute) that uses a single delay slot. One register holds the address now being fetched. A second register holds the next sequential address, which is always one word ahead. When a jump is recognised, the instruction already being fetched in that cycle still goes down the pipe. The target stream starts on the following fetch. An interrupt return also redirects fetch, but it cancels the instruction fetched in its own cycle, so no delay slot executes.

A chain of three history registers records which address entered decode, which entered execute, and which completed execute. Each entry carries a valid bit, so the cancelled slot after an interrupt return appears as a bubble. A stall freezes every register in the unit. Addresses are word aligned: the two low bits of every target are dropped, and sequential addresses advance by 4 modulo 2^ADDR_W.

Top module: `pc_unit`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, fetch_pc equals RESET_ADDR with its two low bits cleared, and dec_vld, exe_vld and done_vld are all 0.
- R2: On a non-stalled cycle with neither br_take nor iret_take, the next fetch_pc equals the current fetch_pc plus 4.
- R3: slave_pc always equals fetch_pc plus 4 (modulo 2^ADDR_W).
- R4: On a non-stalled cycle with br_take high and iret_take low, the next fetch_pc equals br_target, and the address fetched in that cycle enters decode with dec_vld = 1 (the delay slot executes).
- R5: On a non-stalled cycle with iret_take high, the next fetch_pc equals iret_target, and the address fetched in that cycle enters decode with dec_vld = 0 (no delay slot).
- R6: When br_take and iret_take are both high, iret_take wins.
- R7: When stall is high, fetch_pc, slave_pc, the three history addresses and their valid bits keep their values.
- R8: On a non-stalled cycle the history shifts by one stage: dec_pc takes fetch_pc, exe_pc takes dec_pc, and done_pc takes exe_pc. The valid bits move with them.
- R9: Bits 1:0 of fetch_pc are always 0. The two low bits of br_target and iret_target are ignored.
- R10: Sequential fetch wraps from the top word of the address space (all ones except bits 1:0) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze the whole unit for this cycle |
| br_take | input | 1 | Jump recognised; redirect after the delay slot |
| br_target | input | ADDR_W | Jump destination |
| iret_take | input | 1 | Interrupt return; redirect with no delay slot |
| iret_target | input | ADDR_W | Interrupt return destination |
| fetch_pc | output | ADDR_W | Address being fetched |
| slave_pc | output | ADDR_W | Next sequential address |
| dec_pc | output | ADDR_W | Address of the instruction in decode |
| exe_pc | output | ADDR_W | Address of the instruction in execute |
| done_pc | output | ADDR_W | Address of the instruction that completed execute |
| dec_vld | output | 1 | dec_pc holds a live instruction |
| exe_vld | output | 1 | exe_pc holds a live instruction |
| done_vld | output | 1 | done_pc holds a live instruction |

## Verification
The bench builds the unit with ADDR_W = 12 and a nonzero, misaligned RESET_ADDR (0x102). With a 4 KiB address space, both the wrap from 0xFFC to 0 and the reset-address alignment can be reached within a few thousand cycles. The bench runs random mixes of stalls, jumps and interrupt returns with unaligned targets. Directed cases cover both redirects in the same cycle, a stall held during a redirect request, and a jump to the top word.

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              br_take,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              iret_take,
  input  logic [ADDR_W-1:0] iret_target,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] slave_pc,
  output logic [ADDR_W-1:0] dec_pc,
  output logic [ADDR_W-1:0] exe_pc,
  output logic [ADDR_W-1:0] done_pc,
  output logic              dec_vld,
  output logic              exe_vld,
  output logic              done_vld
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] BOOT = RESET_ADDR & MASK;

  logic [ADDR_W-1:0] master_q, slave_q, nxt;

  assign nxt = iret_take ? (iret_target & MASK) :
               br_take   ? (br_target & MASK)   : slave_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q <= BOOT;
      slave_q  <= BOOT + STEP;
      dec_pc   <= '0;
      exe_pc   <= '0;
      done_pc  <= '0;
      dec_vld  <= 1'b0;
      exe_vld  <= 1'b0;
      done_vld <= 1'b0;
    end else if (!stall) begin
      master_q <= nxt;
      slave_q  <= nxt + STEP;
      dec_pc   <= master_q;
      exe_pc   <= dec_pc;
      done_pc  <= exe_pc;
      dec_vld  <= !iret_take;
      exe_vld  <= dec_vld;
      done_vld <= exe_vld;
    end
  end

  assign fetch_pc = master_q;
  assign slave_pc = slave_q;
endmodule

module pc_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              br_take,
  input logic [ADDR_W-1:0] br_target,
  input logic              iret_take,
  input logic [ADDR_W-1:0] iret_target,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [ADDR_W-1:0] slave_pc,
  input logic [ADDR_W-1:0] dec_pc,
  input logic [ADDR_W-1:0] exe_pc,
  input logic [ADDR_W-1:0] done_pc,
  input logic              dec_vld,
  input logic              exe_vld,
  input logic              done_vld
);
  AST_SLAVE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    slave_pc == fetch_pc + ADDR_W'(4)); // R3
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pc[1:0] == 2'b00); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_pc) && $stable(dec_pc) && $stable(exe_pc) && $stable(done_pc))); // R7
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (dec_pc == $past(fetch_pc) && exe_pc == $past(dec_pc) && done_pc == $past(exe_pc))); // R8
  AST_IRET_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && iret_take) |=> (!dec_vld && fetch_pc == ($past(iret_target) & ~ADDR_W'(3)))); // R5
  AST_BR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && br_take && !iret_take) |=> (dec_vld && fetch_pc == ($past(br_target) & ~ADDR_W'(3)))); // R4
endmodule

bind pc_unit pc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .br_take(br_take), .br_target(br_target),
  .iret_take(iret_take), .iret_target(iret_target), .fetch_pc(fetch_pc),
  .slave_pc(slave_pc), .dec_pc(dec_pc), .exe_pc(exe_pc), .done_pc(done_pc),
  .dec_vld(dec_vld), .exe_vld(exe_vld), .done_vld(done_vld)
);

// File: tb/sim_pc_unit.sv
module sim_pc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam logic [AW-1:0] RST_A = 12'h102;

  logic clk = 0, rst_n = 0, stall = 0, br_take = 0, iret_take = 0;
  logic [AW-1:0] br_target = '0, iret_target = '0;
  logic [AW-1:0] fetch_pc, slave_pc, dec_pc, exe_pc, done_pc;
  logic dec_vld, exe_vld, done_vld;

  int checks = 0, errors = 0;
  logic [AW-1:0] em, ed, ee, ew;
  logic edv, eev, ewv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_unit #(.ADDR_W(AW), .RESET_ADDR(RST_A)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .br_take(br_take), .br_target(br_target),
    .iret_take(iret_take), .iret_target(iret_target), .fetch_pc(fetch_pc),
    .slave_pc(slave_pc), .dec_pc(dec_pc), .exe_pc(exe_pc), .done_pc(done_pc),
    .dec_vld(dec_vld), .exe_vld(exe_vld), .done_vld(done_vld));

  function automatic logic [AW-1:0] next_fetch(logic [AW-1:0] m, logic b, logic [AW-1:0] bt,
                                               logic i, logic [AW-1:0] it);
    if (i) return {it[AW-1:2], 2'b00};
    if (b) return {bt[AW-1:2], 2'b00};
    return m + AW'(4);
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    chk(req, fetch_pc, em);
    chk("R3", slave_pc, em + AW'(4));
    chk("R9", {10'b0, fetch_pc[1:0]}, '0);
    chk("R8", dec_pc, ed);
    chk("R8", exe_pc, ee);
    chk("R8", done_pc, ew);
    chk("R8", {9'b0, dec_vld, exe_vld, done_vld}, {9'b0, edv, eev, ewv});
  endtask

  task automatic step(logic s, logic b, logic [AW-1:0] bt, logic i, logic [AW-1:0] it);
    string req;
    stall = s; br_take = b; br_target = bt; iret_take = i; iret_target = it;
    if (s) req = "R7";
    else if (i && b) req = "R6";
    else if (i) req = "R5";
    else if (b) req = "R4";
    else req = "R2";
    if (!s) begin
      ew = ee; ewv = eev; ee = ed; eev = edv; ed = em; edv = !i;
      em = next_fetch(em, b, bt, i, it);
    end
    @(posedge clk); @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    em = {RST_A[AW-1:2], 2'b00}; ed = '0; ee = '0; ew = '0; edv = 0; eev = 0; ewv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", fetch_pc, 12'h100);
    chk("R1", {9'b0, dec_vld, exe_vld, done_vld}, '0);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    // first cycle after reset release: model advanced by one sequential step
    ew = ee; ewv = eev; ee = ed; eev = edv; ed = em; edv = 1; em = em + AW'(4);
    check_all("R1");
    for (int k = 0; k < 4; k++) step(0, 0, '0, 0, '0);
    // R4 jump with unaligned target: delay slot stays valid
    step(0, 1, 12'h2A7, 0, '0);
    step(0, 0, '0, 0, '0);
    // R5 interrupt return: bubble in decode
    step(0, 0, '0, 1, 12'h3C1);
    step(0, 0, '0, 0, '0);
    // R6 both at once
    step(0, 1, 12'h500, 1, 12'h604);
    // R7 stall while a redirect is requested
    step(1, 1, 12'h700, 1, 12'h704);
    step(1, 0, '0, 0, '0);
    step(0, 0, '0, 0, '0);
    // R10 wrap from top word
    step(0, 1, 12'hFFE, 0, '0);
    step(0, 0, '0, 0, '0);
    chk("R10", fetch_pc, 12'h000);
    step(0, 0, '0, 0, '0);
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 15, (r % 7) == 0, AW'($urandom), (r % 11) == 0, AW'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule